// File: doc/BRIEF.md
# Debug Break Comparator

This block watches the processor's bus traffic and raises a break request that sends the core into a debug exception handler. It has two comparison channels, A and B. Each channel takes one of four address buses, compares it with a programmed address under a per-bit mask, and qualifies the result by cycle kind, transfer direction and operand size. Channel B can also compare one of four data buses under a 32-bit mask, and it can require a programmed number of qualifying matches before it fires.

The channels can work independently, so that either one breaks on its own. They can also be chained, so that channel B completes a break only after channel A has matched in an earlier bus cycle. For instruction fetches, each channel chooses whether the break is taken before or after the fetched instruction executes, and the request carries that choice. Software programs the block through a small register write port and reads back which channel matched through two sticky flags.

Top module: `brk_match_top`

## Requirements
- R1: A channel's address compare ignores each bit whose mask bit is 1 and requires equality on every bit whose mask bit is 0.
- R2: Control bits [1:0] select the address bus: 0 logical, 1 internal, 2 X-memory, 3 Y-memory. Bus n occupies bits [n*AW +: AW] of `bus_addr`.
- R3: Control bits [3:2] qualify cycle kind (1 fetch, 2 data, 0 or 3 any). Bits [5:4] qualify direction (1 read, 2 write, 0 or 3 any). Bits [7:6] qualify size (1 byte, 2 word, 3 longword, 0 any), where `cyc_size` is 0 byte, 1 word, 2 longword.
- R4: Channel B also requires the data bus chosen by its control bits [11:10] (same numbering as R2) to equal its data register, except on bits set in its data mask.
- R5: In independent mode (mode register 8, bit 0 = 0), a match on either channel gives `brk_req` high for exactly one clock, in the cycle after the matching bus cycle. Matches on both channels in the same cycle give a single pulse.
- R6: In sequential mode (mode bit 0 = 1), only channel B completes a break, and only once channel A has matched in an earlier cycle. A match of both channels in the same cycle only arms the sequence. Each completed break disarms it.
- R7: Register 9, bits [11:0], sets the repeat count N (0 acts as 1). Channel B breaks on every Nth qualifying match. The count restarts after each break and whenever register 9, the mode register or a channel B register is written.
- R8: `brk_post` is 1 with `brk_req` only when every channel firing in that cycle has control bit 8 (after-execution) set and the cycle was a fetch. Otherwise it is 0, so a before-execution request takes precedence.
- R9: `flag_a` is set by a channel A match and `flag_b` by a channel B break. The flags stay set until software writes register 10 with bit 0 (to clear A) or bit 1 (to clear B) set.
- R10: A channel whose control bit 9 (enable) is 0 never matches and never sets its flag.
- R11: Writing the mode register or any channel A register (0 address, 1 mask, 2 control) disarms a pending sequence.
- R12: After reset, all outputs are 0, both channels are disabled and independent mode is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 4 | Register select: 0-2 A addr/mask/ctrl, 3-5 B addr/mask/ctrl, 6 B data, 7 B data mask, 8 mode, 9 repeat, 10 flag clear |
| cfg_wdata | input | 32 | Configuration write data |
| bus_addr | input | 4*AW | Four address buses, logical in the lowest slice |
| bus_data | input | 4*DW | Four data buses, same order |
| cyc_valid | input | 1 | A bus cycle is present this clock |
| cyc_fetch | input | 1 | 1 instruction fetch, 0 data access |
| cyc_write | input | 1 | 1 write, 0 read |
| cyc_size | input | 2 | Operand size: 0 byte, 1 word, 2 longword |
| brk_req | output | 1 | Registered break request pulse |
| brk_post | output | 1 | Break is to be taken after the instruction executes |
| flag_a | output | 1 | Sticky channel A match flag |
| flag_b | output | 1 | Sticky channel B break flag |

## Verification
Both channels can match in the same bus cycle, and the bench provokes this deliberately. In independent mode it places channel A's address on the logical bus and channel B's address on the internal bus during one fetch. It then checks for exactly one request pulse, followed by an idle clock, and for the before-execution choice winning whenever the two channels disagree on timing. In sequential mode the same coincident cycle must only arm the sequence, and a following B-only cycle must then complete it.

// File: rtl/brk_pkg.sv
package brk_pkg;
  localparam int BUS_COUNT = 4;

  typedef enum logic [3:0] {
    SEL_A_ADDR  = 4'd0,
    SEL_A_MASK  = 4'd1,
    SEL_A_CTRL  = 4'd2,
    SEL_B_ADDR  = 4'd3,
    SEL_B_MASK  = 4'd4,
    SEL_B_CTRL  = 4'd5,
    SEL_B_DATA  = 4'd6,
    SEL_B_DMASK = 4'd7,
    SEL_MODE    = 4'd8,
    SEL_REPEAT  = 4'd9,
    SEL_CLEAR   = 4'd10
  } cfg_sel_e;

  // Channel control word: 12 bits, LSB first abus, kind, dir, size, post, enable, dbus
  typedef struct packed {
    logic [1:0] dbus;
    logic       enable;
    logic       post;
    logic [1:0] size;
    logic [1:0] dir;
    logic [1:0] kind;
    logic [1:0] abus;
  } chan_ctrl_t;

  localparam int CTRL_W = $bits(chan_ctrl_t);
endpackage

// File: rtl/brk_chan.sv
module brk_chan
  import brk_pkg::*;
#(
  parameter int AW       = 32,
  parameter int DW       = 32,
  parameter int CW       = 32,
  parameter bit HAS_DATA = 1'b0
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_addr,
  input  logic                    wr_mask,
  input  logic                    wr_ctrl,
  input  logic                    wr_data,
  input  logic                    wr_dmask,
  input  logic [CW-1:0]           wdata,
  input  logic [BUS_COUNT*AW-1:0] bus_addr,
  input  logic [BUS_COUNT*DW-1:0] bus_data,
  input  logic                    cyc_valid,
  input  logic                    cyc_fetch,
  input  logic                    cyc_write,
  input  logic [1:0]              cyc_size,
  output logic                    hit,
  output logic                    post_req
);
  logic [AW-1:0] addr_q, amask_q, sel_addr;
  chan_ctrl_t    ctrl_q;
  logic          addr_ok, kind_ok, dir_ok, size_ok, data_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      amask_q <= '0;
      ctrl_q  <= '0;
    end else begin
      if (wr_addr) addr_q  <= wdata[AW-1:0];
      if (wr_mask) amask_q <= wdata[AW-1:0];
      if (wr_ctrl) ctrl_q  <= chan_ctrl_t'(wdata[CTRL_W-1:0]);
    end
  end

  always_comb sel_addr = bus_addr[ctrl_q.abus*AW +: AW];

  assign addr_ok = ((sel_addr ^ addr_q) & ~amask_q) == '0;
  assign kind_ok = (ctrl_q.kind == 2'd0) || (ctrl_q.kind == 2'd3) ||
                   (ctrl_q.kind == 2'd1 && cyc_fetch) || (ctrl_q.kind == 2'd2 && !cyc_fetch);
  assign dir_ok  = (ctrl_q.dir == 2'd0) || (ctrl_q.dir == 2'd3) ||
                   (ctrl_q.dir == 2'd1 && !cyc_write) || (ctrl_q.dir == 2'd2 && cyc_write);
  assign size_ok = (ctrl_q.size == 2'd0) || (cyc_size == ctrl_q.size - 2'd1);

  generate
    if (HAS_DATA) begin : g_data
      logic [DW-1:0] data_q, dmask_q, sel_data;
      always_ff @(posedge clk) begin
        if (rst) begin
          data_q  <= '0;
          dmask_q <= '0;
        end else begin
          if (wr_data)  data_q  <= wdata[DW-1:0];
          if (wr_dmask) dmask_q <= wdata[DW-1:0];
        end
      end
      always_comb sel_data = bus_data[ctrl_q.dbus*DW +: DW];
      assign data_ok = ((sel_data ^ data_q) & ~dmask_q) == '0;
    end else begin : g_nodata
      logic unused_data_in;
      assign unused_data_in = ^{bus_data, wr_data, wr_dmask, ctrl_q.dbus};
      assign data_ok = 1'b1;
    end
  endgenerate

  assign hit      = cyc_valid && ctrl_q.enable && addr_ok && kind_ok && dir_ok && size_ok && data_ok;
  assign post_req = ctrl_q.post && cyc_fetch;
endmodule

// File: rtl/brk_ctrl.sv
module brk_ctrl #(
  parameter int RW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hit_a,
  input  logic          hit_b,
  input  logic          post_a,
  input  logic          post_b,
  input  logic          seq_mode,
  input  logic [RW-1:0] rpt,
  input  logic          arm_clr,
  input  logic          cnt_clr,
  input  logic          clr_a,
  input  logic          clr_b,
  output logic          brk_req,
  output logic          brk_post,
  output logic          flag_a,
  output logic          flag_b
);
  logic [RW-1:0] cnt_q, rpt_eff;
  logic          armed_q, b_count, b_done, fire_a, fire;

  assign rpt_eff = (rpt == '0) ? RW'(1) : rpt;
  assign b_count = hit_b && (!seq_mode || armed_q);
  assign b_done  = b_count && ({1'b0, cnt_q} + 1'b1 == {1'b0, rpt_eff});
  assign fire_a  = hit_a && !seq_mode;
  assign fire    = fire_a || b_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      armed_q  <= 1'b0;
      brk_req  <= 1'b0;
      brk_post <= 1'b0;
      flag_a   <= 1'b0;
      flag_b   <= 1'b0;
    end else begin
      if (cnt_clr)      cnt_q <= '0;
      else if (b_count) cnt_q <= b_done ? '0 : cnt_q + 1'b1;

      if (arm_clr)                 armed_q <= 1'b0;
      else if (!seq_mode || b_done) armed_q <= 1'b0;
      else if (hit_a)              armed_q <= 1'b1;

      brk_req  <= fire;
      brk_post <= fire && (!fire_a || post_a) && (!b_done || post_b);
      flag_a   <= (flag_a && !clr_a) || hit_a;
      flag_b   <= (flag_b && !clr_b) || b_done;
    end
  end

  assert_seq_order_R6: assert property (@(posedge clk) disable iff (rst)
    (brk_req && $past(seq_mode)) |-> $past(armed_q));
  assert_rpt_bound_R7: assert property (@(posedge clk) disable iff (rst)
    cnt_q < rpt_eff);
  assert_flag_source_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_a) |-> $past(hit_a));
  assert_disarm_R11: assert property (@(posedge clk) disable iff (rst)
    $past(arm_clr) |-> !armed_q);
  assert_req_source_R5: assert property (@(posedge clk) disable iff (rst)
    brk_req |-> $past(hit_a || hit_b));
endmodule

// File: rtl/brk_match_top.sv
module brk_match_top
  import brk_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 32,
  parameter int RW = 12
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cfg_we,
  input  logic [3:0]              cfg_sel,
  input  logic [CW-1:0]           cfg_wdata,
  input  logic [BUS_COUNT*AW-1:0] bus_addr,
  input  logic [BUS_COUNT*DW-1:0] bus_data,
  input  logic                    cyc_valid,
  input  logic                    cyc_fetch,
  input  logic                    cyc_write,
  input  logic [1:0]              cyc_size,
  output logic                    brk_req,
  output logic                    brk_post,
  output logic                    flag_a,
  output logic                    flag_b
);
  logic          seq_q;
  logic [RW-1:0] rpt_q;
  logic          hit_a, hit_b, post_a, post_b;
  logic          w_a_addr, w_a_mask, w_a_ctrl, w_b_addr, w_b_mask, w_b_ctrl;
  logic          w_b_data, w_b_dmask, w_mode, w_rpt, w_clr;

  assign w_a_addr  = cfg_we && cfg_sel == SEL_A_ADDR;
  assign w_a_mask  = cfg_we && cfg_sel == SEL_A_MASK;
  assign w_a_ctrl  = cfg_we && cfg_sel == SEL_A_CTRL;
  assign w_b_addr  = cfg_we && cfg_sel == SEL_B_ADDR;
  assign w_b_mask  = cfg_we && cfg_sel == SEL_B_MASK;
  assign w_b_ctrl  = cfg_we && cfg_sel == SEL_B_CTRL;
  assign w_b_data  = cfg_we && cfg_sel == SEL_B_DATA;
  assign w_b_dmask = cfg_we && cfg_sel == SEL_B_DMASK;
  assign w_mode    = cfg_we && cfg_sel == SEL_MODE;
  assign w_rpt     = cfg_we && cfg_sel == SEL_REPEAT;
  assign w_clr     = cfg_we && cfg_sel == SEL_CLEAR;

  always_ff @(posedge clk) begin
    if (rst) begin
      seq_q <= 1'b0;
      rpt_q <= '0;
    end else begin
      if (w_mode) seq_q <= cfg_wdata[0];
      if (w_rpt)  rpt_q <= cfg_wdata[RW-1:0];
    end
  end

  brk_chan #(.AW(AW), .DW(DW), .CW(CW), .HAS_DATA(1'b0)) u_chan_a (
    .clk(clk), .rst(rst),
    .wr_addr(w_a_addr), .wr_mask(w_a_mask), .wr_ctrl(w_a_ctrl),
    .wr_data(1'b0), .wr_dmask(1'b0), .wdata(cfg_wdata),
    .bus_addr(bus_addr), .bus_data(bus_data),
    .cyc_valid(cyc_valid), .cyc_fetch(cyc_fetch), .cyc_write(cyc_write), .cyc_size(cyc_size),
    .hit(hit_a), .post_req(post_a)
  );

  brk_chan #(.AW(AW), .DW(DW), .CW(CW), .HAS_DATA(1'b1)) u_chan_b (
    .clk(clk), .rst(rst),
    .wr_addr(w_b_addr), .wr_mask(w_b_mask), .wr_ctrl(w_b_ctrl),
    .wr_data(w_b_data), .wr_dmask(w_b_dmask), .wdata(cfg_wdata),
    .bus_addr(bus_addr), .bus_data(bus_data),
    .cyc_valid(cyc_valid), .cyc_fetch(cyc_fetch), .cyc_write(cyc_write), .cyc_size(cyc_size),
    .hit(hit_b), .post_req(post_b)
  );

  brk_ctrl #(.RW(RW)) u_ctrl (
    .clk(clk), .rst(rst),
    .hit_a(hit_a), .hit_b(hit_b), .post_a(post_a), .post_b(post_b),
    .seq_mode(seq_q), .rpt(rpt_q),
    .arm_clr(w_mode || w_a_addr || w_a_mask || w_a_ctrl),
    .cnt_clr(w_rpt || w_mode || w_b_addr || w_b_mask || w_b_ctrl || w_b_data || w_b_dmask),
    .clr_a(w_clr && cfg_wdata[0]), .clr_b(w_clr && cfg_wdata[1]),
    .brk_req(brk_req), .brk_post(brk_post), .flag_a(flag_a), .flag_b(flag_b)
  );
endmodule

// File: tb/brk_match_top_tb.sv
`timescale 1ns/1ps
module brk_match_top_tb;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cfg_we = 1'b0;
  logic [3:0]   cfg_sel = '0;
  logic [31:0]  cfg_wdata = '0;
  logic [127:0] bus_addr = '0, bus_data = '0;
  logic         cyc_valid = 1'b0, cyc_fetch = 1'b0, cyc_write = 1'b0;
  logic [1:0]   cyc_size = '0;
  logic         brk_req, brk_post, flag_a, flag_b;
  int           vectors = 0, fails = 0;

  localparam logic [31:0] CA = 32'h1234_5678, AMSK = 32'h0000_00F0;
  localparam logic [31:0] CB = 32'h0000_0100, DB = 32'hCAFE_0000;

  always #10 clk = ~clk;

  brk_match_top u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .bus_addr(bus_addr), .bus_data(bus_data), .cyc_valid(cyc_valid), .cyc_fetch(cyc_fetch),
    .cyc_write(cyc_write), .cyc_size(cyc_size), .brk_req(brk_req), .brk_post(brk_post),
    .flag_a(flag_a), .flag_b(flag_b)
  );

  function automatic logic [31:0] mk(input int abus, kind, dir, size, post, en, dbus);
    return 32'((dbus << 10) | (en << 9) | (post << 8) | (size << 6) | (dir << 4) | (kind << 2) | abus);
  endfunction

  function automatic logic [127:0] put(input int slot, input logic [31:0] v, input logic [31:0] fill);
    logic [127:0] r;
    r = {4{fill}};
    r[slot*32 +: 32] = v;
    return r;
  endfunction

  function automatic logic qual(input int kind, dir, size, input logic f, w, input int s);
    logic k, d, z;
    k = (kind == 0) || (kind == 3) || (kind == 1 && f) || (kind == 2 && !f);
    d = (dir == 0) || (dir == 3) || (dir == 1 && !w) || (dir == 2 && w);
    z = (size == 0) || (s == size - 1);
    return k && d && z;
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic cfg(input int sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 4'(sel); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cyc(input logic [127:0] a, input logic [127:0] d, input logic f, w, input int s);
    @(negedge clk);
    bus_addr = a; bus_data = d; cyc_fetch = f; cyc_write = w; cyc_size = 2'(s); cyc_valid = 1'b1;
    @(negedge clk);
    cyc_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [127:0] both, aonly, bonly;
    both  = '0; both[31:0] = CA; both[63:32] = CB;
    aonly = '0; aonly[31:0] = CA;
    bonly = '0; bonly[31:0] = ~CA; bonly[63:32] = CB;

    repeat (4) @(negedge clk);
    chk("R12 brk_req", brk_req, 1'b0);
    chk("R12 brk_post", brk_post, 1'b0);
    chk("R12 flag_a", flag_a, 1'b0);
    chk("R12 flag_b", flag_b, 1'b0);
    rst = 1'b0;

    cfg(0, CA); cfg(1, AMSK); cfg(2, mk(0, 0, 0, 0, 0, 1, 0));
    // R1: exact match, then every single-bit flip
    cyc(put(0, CA, ~CA), '0, 1'b1, 1'b0, 2);
    chk("R1 exact", brk_req, 1'b1);
    for (int i = 0; i < 32; i++) begin
      cyc(put(0, CA ^ (32'd1 << i), ~CA), '0, 1'b1, 1'b0, 2);
      chk("R1 bit flip", brk_req, AMSK[i]);
    end
    // R2: bus select against bus carrying the address
    for (int s = 0; s < 4; s++) begin
      cfg(2, mk(s, 0, 0, 0, 0, 1, 0));
      for (int t = 0; t < 4; t++) begin
        cyc(put(t, CA, 32'h0), '0, 1'b0, 1'b0, 0);
        chk("R2 bus select", brk_req, s == t);
      end
    end
    // R3: exhaustive qualifier sweep
    for (int k = 0; k < 4; k++)
      for (int d = 0; d < 4; d++)
        for (int z = 0; z < 4; z++) begin
          cfg(2, mk(0, k, d, z, 0, 1, 0));
          for (int f = 0; f < 2; f++)
            for (int w = 0; w < 2; w++)
              for (int s = 0; s < 3; s++) begin
                cyc(put(0, CA, 32'h0), '0, f[0], w[0], s);
                chk("R3 qualifier", brk_req, qual(k, d, z, f[0], w[0], s));
              end
        end
    // R10: disabled channel
    cfg(10, 32'd3);
    cfg(2, mk(0, 0, 0, 0, 0, 0, 0));
    cyc(put(0, CA, 32'h0), '0, 1'b1, 1'b0, 2);
    chk("R10 disabled req", brk_req, 1'b0);
    chk("R10 disabled flag", flag_a, 1'b0);
    // R9: sticky flag and clear
    cfg(2, mk(0, 0, 0, 0, 0, 1, 0));
    cyc(put(0, CA, 32'h0), '0, 1'b1, 1'b0, 2);
    chk("R9 flag set", flag_a, 1'b1);
    cyc(put(0, ~CA, 32'h0), '0, 1'b1, 1'b0, 2);
    chk("R9 flag held", flag_a, 1'b1);
    chk("R9 no req", brk_req, 1'b0);
    cfg(10, 32'd2);
    chk("R9 wrong clear bit", flag_a, 1'b1);
    cfg(10, 32'd1);
    chk("R9 flag cleared", flag_a, 1'b0);
    // R4: channel B data compare
    cfg(2, mk(0, 0, 0, 0, 0, 0, 0));
    cfg(3, CB); cfg(4, 32'h0); cfg(6, DB); cfg(7, 32'h0000_FFFF);
    cfg(5, mk(1, 0, 0, 0, 0, 1, 2));
    for (int t = 0; t < 4; t++) begin
      cyc(put(1, CB, 32'h0), put(t, 32'hCAFE_1234, 32'h0), 1'b0, 1'b0, 2);
      chk("R4 data bus select", brk_req, t == 2);
    end
    for (int i = 0; i < 32; i++) begin
      cyc(put(1, CB, 32'h0), put(2, DB ^ (32'd1 << i), 32'h0), 1'b0, 1'b1, 2);
      chk("R4 data mask", brk_req, i < 16);
    end
    chk("R9 flag_b set", flag_b, 1'b1);
    // R7: repeat count
    cfg(9, 32'd5);
    for (int k = 1; k <= 12; k++) begin
      cyc(put(1, CB, 32'h0), put(2, DB, 32'h0), 1'b0, 1'b0, 2);
      chk("R7 repeat 5", brk_req, (k % 5) == 0);
    end
    cfg(9, 32'd0);
    cyc(put(1, CB, 32'h0), put(2, DB, 32'h0), 1'b0, 1'b0, 2);
    chk("R7 repeat 0 as 1", brk_req, 1'b1);
    cfg(9, 32'd5);
    for (int k = 0; k < 3; k++) cyc(put(1, CB, 32'h0), put(2, DB, 32'h0), 1'b0, 1'b0, 2);
    cfg(9, 32'd5);
    for (int k = 1; k <= 5; k++) begin
      cyc(put(1, CB, 32'h0), put(2, DB, 32'h0), 1'b0, 1'b0, 2);
      chk("R7 restart on write", brk_req, k == 5);
    end
    cfg(9, 32'd4095);
    for (int k = 1; k <= 4095; k++) begin
      cyc(put(1, CB, 32'h0), put(2, DB, 32'h0), 1'b0, 1'b0, 2);
      chk("R7 repeat max", brk_req, k == 4095);
    end
    // R8: timing selection
    cfg(9, 32'd1);
    cfg(5, 32'h0);
    cfg(2, mk(0, 0, 0, 0, 1, 1, 0));
    cyc(put(0, CA, 32'h0), '0, 1'b1, 1'b0, 2);
    chk("R8 post fetch req", brk_req, 1'b1);
    chk("R8 post fetch", brk_post, 1'b1);
    cyc(put(0, CA, 32'h0), '0, 1'b0, 1'b0, 2);
    chk("R8 data access req", brk_req, 1'b1);
    chk("R8 data access post", brk_post, 1'b0);
    cfg(2, mk(0, 0, 0, 0, 0, 1, 0));
    cyc(put(0, CA, 32'h0), '0, 1'b1, 1'b0, 2);
    chk("R8 pre fetch", brk_post, 1'b0);
    // R5: both channels in one cycle
    cfg(7, 32'hFFFF_FFFF);
    cfg(2, mk(0, 0, 0, 0, 1, 1, 0));
    cfg(5, mk(1, 0, 0, 0, 0, 1, 0));
    cyc(both, '0, 1'b1, 1'b0, 2);
    chk("R5 coincident req", brk_req, 1'b1);
    chk("R8 pre wins", brk_post, 1'b0);
    @(negedge clk);
    chk("R5 single pulse", brk_req, 1'b0);
    cfg(5, mk(1, 0, 0, 0, 1, 1, 0));
    cyc(both, '0, 1'b1, 1'b0, 2);
    chk("R8 both post", brk_post, 1'b1);
    cyc(bonly, '0, 1'b1, 1'b0, 2);
    chk("R5 B alone", brk_req, 1'b1);
    cyc(aonly, '0, 1'b1, 1'b0, 2);
    chk("R5 A alone", brk_req, 1'b1);
    // R6: sequential mode
    cfg(8, 32'd1);
    cyc(bonly, '0, 1'b1, 1'b0, 2);
    chk("R6 B before A", brk_req, 1'b0);
    cyc(aonly, '0, 1'b1, 1'b0, 2);
    chk("R6 A alone no break", brk_req, 1'b0);
    cyc(bonly, '0, 1'b1, 1'b0, 2);
    chk("R6 A then B", brk_req, 1'b1);
    cyc(bonly, '0, 1'b1, 1'b0, 2);
    chk("R6 disarmed after break", brk_req, 1'b0);
    cyc(both, '0, 1'b1, 1'b0, 2);
    chk("R6 same cycle no break", brk_req, 1'b0);
    cyc(bonly, '0, 1'b1, 1'b0, 2);
    chk("R6 same cycle arms", brk_req, 1'b1);
    // R11: rewrites disarm
    cyc(aonly, '0, 1'b1, 1'b0, 2);
    cfg(1, AMSK);
    cyc(bonly, '0, 1'b1, 1'b0, 2);
    chk("R11 A rewrite disarms", brk_req, 1'b0);
    cyc(aonly, '0, 1'b1, 1'b0, 2);
    cfg(8, 32'd1);
    cyc(bonly, '0, 1'b1, 1'b0, 2);
    chk("R11 mode rewrite disarms", brk_req, 1'b0);
    cyc(aonly, '0, 1'b1, 1'b0, 2);
    cfg(3, CB);
    cyc(bonly, '0, 1'b1, 1'b0, 2);
    chk("R11 B rewrite keeps arm", brk_req, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule